// File: doc/BRIEF.md
# Four-Bank Flash Busy-Bank Arbiter

This block sits between the host-side access path and a four-bank flash array, so that reads can go on while a program or erase runs in one bank. Every word address is split into a bank number and a sector index using the array's uneven sector map. The two outer banks each hold eight small boot sectors plus fifteen large sectors. The two middle banks each hold forty-eight large sectors. In total there are 142 sectors.

The arbiter keeps track of the single bank, if any, that holds an embedded operation. A read that lands in any other bank is steered to the array data path in the same cycle. A read that lands in the busy bank is steered to the status path instead. A start request is accepted only while no bank is busy, and only if write protection does not cover its sector. When the operation timer reports completion, the bank drops back to read mode with no further command. The active-high `idle` output is the ready/busy indication.

Top module: `flash_bank_arbiter`

## Requirements
- R1: `rd_bank` gives the bank of `rd_addr` in the same cycle. Bank 0 covers word addresses 0x000000–0x07FFFF, bank 1 covers 0x080000–0x1FFFFF, bank 2 covers 0x200000–0x37FFFF and bank 3 covers 0x380000–0x3FFFFF.
- R2: `rd_sector` gives the sector index of `rd_addr` in the same cycle, as follows. Sectors 0–7 are 4096 words each, from address 0. Sectors 8–133 are 32768 words each, from 0x008000. Sectors 134–141 are 4096 words each, from 0x3F8000.
- R3: A read (`rd_valid`=1) to a bank that is not busy sets `rd_array_en`=1 and `rd_use_status`=0 in the same cycle.
- R4: A read to the busy bank sets `rd_use_status`=1 and `rd_array_en`=0 in the same cycle. With `rd_valid`=0, both outputs are 0.
- R5: An accepted start produces the following in the next cycle: `op_ack`=1 for exactly one cycle, `idle`=0, and `busy_bank` set to the bank of `op_addr`.
- R6: A start while a bank is busy is refused. In the next cycle `op_err`=1 for one cycle, `op_ack`=0 and `busy_bank` is unchanged. `idle` stays 0 unless `op_finish` came in the same cycle.
- R7: With `wr_protect_n`=0, a start to sector 0, 1, 140 or 141 is refused: `op_err` pulses and `idle` stays 1. Other sectors are accepted while `wr_protect_n`=0, and these four sectors are accepted while `wr_protect_n`=1.
- R8: `op_finish` while busy sets `idle`=1 in the next cycle. After that, reads to the former busy bank use the array path.
- R9: `op_finish` while idle has no effect on `idle`, `op_ack` or `op_err`.
- R10: With `rst`=1 at a clock edge, the next cycle shows `idle`=1, `op_ack`=0 and `op_err`=0, whatever state came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_valid | input | 1 | A read is presented this cycle |
| rd_addr | input | 22 | Word address of the read |
| op_start | input | 1 | Request to start a program or erase |
| op_addr | input | 22 | Word address targeted by the start request |
| op_finish | input | 1 | Completion pulse from the operation timer |
| wr_protect_n | input | 1 | Active-low boot-sector write protection |
| rd_bank | output | 2 | Bank of the read address |
| rd_sector | output | 8 | Sector index of the read address |
| rd_array_en | output | 1 | Read is served from array data |
| rd_use_status | output | 1 | Read is served from the status path |
| idle | output | 1 | High when no embedded operation runs |
| busy_bank | output | 2 | Bank that holds, or last held, the operation |
| op_ack | output | 1 | One-cycle pulse: start request accepted |
| op_err | output | 1 | One-cycle pulse: start request refused |

## Verification
The bench builds the block with the package's default geometry: a 22-bit word address, 4096-word boot sectors and 32768-word large sectors. With these values every bank edge and both boot regions fall at fixed word addresses that the bench can hit directly. The bench probes the first and last word of each region, reads every bank while a chosen bank is busy, and reaches all four protected sectors as well as their nearest unprotected neighbours. It also drives a completion pulse together with a refused start in the same cycle, and applies a reset in the middle of an operation.

// File: rtl/flash_bank_pkg.sv
package flash_bank_pkg;
    parameter int ADDR_W       = 22;
    parameter int SMALL_SHIFT  = 12;
    parameter int LARGE_SHIFT  = 15;
    parameter int EDGE_LARGE   = 15;
    parameter int MID_LARGE    = 48;
    parameter int BANK_W       = 2;
    parameter int GUARD_EACH   = 2;

    localparam int N_BOOT_SMALL = 1 << (LARGE_SHIFT - SMALL_SHIFT);
    localparam int UNIT_W       = ADDR_W - LARGE_SHIFT;
    localparam int SUB_W        = LARGE_SHIFT - SMALL_SHIFT;
    localparam int EDGE_UNITS   = EDGE_LARGE + 1;
    localparam int B1_START     = EDGE_UNITS;
    localparam int B2_START     = B1_START + MID_LARGE;
    localparam int B3_START     = B2_START + MID_LARGE;
    localparam int TOP_UNIT     = B3_START + EDGE_UNITS - 1;
    localparam int N_SECTORS    = 2 * (N_BOOT_SMALL + EDGE_LARGE) + 2 * MID_LARGE;
    localparam int SEC_W        = $clog2(N_SECTORS);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [SEC_W-1:0]  sector_t;

    typedef struct packed {
        bank_t   bank;
        sector_t sector;
    } loc_t;

    typedef enum logic [1:0] {
        DEC_NONE,
        DEC_ACCEPT,
        DEC_BUSY,
        DEC_GUARDED
    } start_dec_t;

    function automatic loc_t locate(addr_t a);
        loc_t                 l;
        logic [UNIT_W-1:0]    unit;
        logic [SUB_W-1:0]     sub;
        unit = a[ADDR_W-1:LARGE_SHIFT];
        sub  = a[LARGE_SHIFT-1:SMALL_SHIFT];
        if (unit < UNIT_W'(B1_START))      l.bank = bank_t'(0);
        else if (unit < UNIT_W'(B2_START)) l.bank = bank_t'(1);
        else if (unit < UNIT_W'(B3_START)) l.bank = bank_t'(2);
        else                               l.bank = bank_t'(3);
        if (unit == '0)
            l.sector = SEC_W'(sub);
        else if (unit == UNIT_W'(TOP_UNIT))
            l.sector = SEC_W'(N_SECTORS - N_BOOT_SMALL) + SEC_W'(sub);
        else
            l.sector = SEC_W'(unit) + SEC_W'(N_BOOT_SMALL - 1);
        return l;
    endfunction

    function automatic logic is_guarded(sector_t s);
        return (s < SEC_W'(GUARD_EACH)) || (s >= SEC_W'(N_SECTORS - GUARD_EACH));
    endfunction
endpackage

// File: rtl/fba_locator.sv
module fba_locator
    import flash_bank_pkg::*;
(
    input  addr_t addr,
    output loc_t  loc
);
    always_comb loc = locate(addr);
endmodule

// File: rtl/fba_busy_tracker.sv
module fba_busy_tracker
    import flash_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  op_start,
    input  loc_t  op_loc,
    input  logic  op_finish,
    input  logic  wr_protect_n,
    output logic  busy,
    output bank_t busy_bank,
    output logic  op_ack,
    output logic  op_err
);
    start_dec_t dec;

    always_comb begin
        if (!op_start)                                       dec = DEC_NONE;
        else if (busy)                                       dec = DEC_BUSY;
        else if (!wr_protect_n && is_guarded(op_loc.sector)) dec = DEC_GUARDED;
        else                                                 dec = DEC_ACCEPT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            busy_bank <= '0;
            op_ack    <= 1'b0;
            op_err    <= 1'b0;
        end else begin
            op_ack <= (dec == DEC_ACCEPT);
            op_err <= (dec == DEC_BUSY) || (dec == DEC_GUARDED);
            if (dec == DEC_ACCEPT) begin
                busy      <= 1'b1;
                busy_bank <= op_loc.bank;
            end else if (op_finish) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fba_read_router.sv
module fba_read_router
    import flash_bank_pkg::*;
(
    input  logic  rd_valid,
    input  bank_t rd_bank,
    input  logic  busy,
    input  bank_t busy_bank,
    output logic  rd_array_en,
    output logic  rd_use_status
);
    logic hit_busy;

    always_comb begin
        hit_busy      = busy && (rd_bank == busy_bank);
        rd_use_status = rd_valid && hit_busy;
        rd_array_en   = rd_valid && !hit_busy;
    end
endmodule

// File: rtl/flash_bank_arbiter.sv
module flash_bank_arbiter
    import flash_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              op_start,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              op_finish,
    input  logic              wr_protect_n,
    output logic [BANK_W-1:0] rd_bank,
    output logic [SEC_W-1:0]  rd_sector,
    output logic              rd_array_en,
    output logic              rd_use_status,
    output logic              idle,
    output logic [BANK_W-1:0] busy_bank,
    output logic              op_ack,
    output logic              op_err
);
    loc_t  rd_loc;
    loc_t  op_loc;
    logic  busy;
    bank_t bb;
    sector_t op_sector;

    fba_locator u_rd_loc (.addr(rd_addr), .loc(rd_loc));
    fba_locator u_op_loc (.addr(op_addr), .loc(op_loc));

    fba_busy_tracker u_track (
        .clk(clk), .rst(rst), .op_start(op_start), .op_loc(op_loc),
        .op_finish(op_finish), .wr_protect_n(wr_protect_n),
        .busy(busy), .busy_bank(bb), .op_ack(op_ack), .op_err(op_err)
    );

    fba_read_router u_route (
        .rd_valid(rd_valid), .rd_bank(rd_loc.bank), .busy(busy), .busy_bank(bb),
        .rd_array_en(rd_array_en), .rd_use_status(rd_use_status)
    );

    assign rd_bank   = rd_loc.bank;
    assign rd_sector = rd_loc.sector;
    assign idle      = !busy;
    assign busy_bank = bb;
    assign op_sector = op_loc.sector;
endmodule

// File: rtl/fba_checker.sv
module fba_checker
    import flash_bank_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    rd_valid,
    input bank_t   rd_bank,
    input logic    op_start,
    input logic    op_finish,
    input logic    wr_protect_n,
    input sector_t op_sector,
    input logic    rd_array_en,
    input logic    rd_use_status,
    input logic    idle,
    input bank_t   busy_bank,
    input logic    op_ack,
    input logic    op_err
);
    AST_IDLE_READ_ARRAY: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && idle) |-> (rd_array_en && !rd_use_status)); // R3

    AST_STATUS_ONLY_BUSY_BANK: assert property (@(posedge clk) disable iff (rst)
        rd_use_status |-> (!idle && rd_bank == busy_bank && !rd_array_en)); // R4

    AST_ACK_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
        op_ack |-> !idle); // R5

    AST_ACK_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(op_ack && op_err)); // R6

    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
        (op_start && !idle && !op_finish) |=> (op_err && !idle && $stable(busy_bank))); // R6

    AST_BOOT_LOCK: assert property (@(posedge clk) disable iff (rst)
        (op_start && idle && !wr_protect_n &&
         (op_sector < SEC_W'(GUARD_EACH) || op_sector >= SEC_W'(N_SECTORS - GUARD_EACH)))
        |=> (op_err && idle)); // R7

    AST_FINISH_FREES: assert property (@(posedge clk) disable iff (rst)
        (op_finish && !idle) |=> idle); // R8

    AST_IDLE_FINISH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (op_finish && idle && !op_start) |=> (idle && !op_ack && !op_err)); // R9
endmodule

bind flash_bank_arbiter fba_checker u_chk (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_bank(rd_bank),
    .op_start(op_start), .op_finish(op_finish), .wr_protect_n(wr_protect_n),
    .op_sector(op_sector), .rd_array_en(rd_array_en), .rd_use_status(rd_use_status),
    .idle(idle), .busy_bank(busy_bank), .op_ack(op_ack), .op_err(op_err)
);

// File: tb/flash_bank_arbiter_test.sv
`timescale 1ns/100ps
module flash_bank_arbiter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_valid = 1'b0;
    logic [21:0] rd_addr = '0;
    logic        op_start = 1'b0;
    logic [21:0] op_addr = '0;
    logic        op_finish = 1'b0;
    logic        wr_protect_n = 1'b1;
    logic [1:0]  rd_bank;
    logic [7:0]  rd_sector;
    logic        rd_array_en, rd_use_status, idle, op_ack, op_err;
    logic [1:0]  busy_bank;

    always #2.5 clk = ~clk;

    flash_bank_arbiter uut (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .op_start(op_start), .op_addr(op_addr), .op_finish(op_finish),
        .wr_protect_n(wr_protect_n), .rd_bank(rd_bank), .rd_sector(rd_sector),
        .rd_array_en(rd_array_en), .rd_use_status(rd_use_status), .idle(idle),
        .busy_bank(busy_bank), .op_ack(op_ack), .op_err(op_err)
    );

    typedef struct {
        bit    chk_reg;
        bit    idle, ack, err;
        int    bb;
        bit    rdv;
        int    bank, sec;
        bit    stat, arr;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    bit m_known = 0;
    bit m_busy = 0, m_ack = 0, m_err = 0;
    int m_bb = 0;

    function automatic int m_bank(int a);
        if (a < 'h080000) return 0;
        if (a < 'h200000) return 1;
        if (a < 'h380000) return 2;
        return 3;
    endfunction

    function automatic int m_sec(int a);
        case (m_bank(a))
            0: return (a < 'h8000) ? a / 4096 : 8 + (a - 'h8000) / 32768;
            1: return 23 + (a - 'h080000) / 32768;
            2: return 71 + (a - 'h200000) / 32768;
            default: return (a >= 'h3F8000) ? 134 + (a - 'h3F8000) / 4096
                                            : 119 + (a - 'h380000) / 32768;
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(bit r, bit rv, int ra, bit st, int oa, bit fin, bit wp, string req);
        exp_t e;
        bit   lock;
        @(negedge clk);
        rst = r; rd_valid = rv; rd_addr = 22'(ra); op_start = st;
        op_addr = 22'(oa); op_finish = fin; wr_protect_n = wp;
        e.chk_reg = m_known;
        e.idle = !m_busy; e.ack = m_ack; e.err = m_err; e.bb = m_bb;
        e.rdv = rv; e.bank = m_bank(ra); e.sec = m_sec(ra);
        e.stat = rv && m_busy && (m_bank(ra) == m_bb);
        e.arr = rv && !e.stat;
        e.req = req;
        exp_q.push_back(e);
        if (r) begin
            m_busy = 0; m_ack = 0; m_err = 0; m_bb = 0; m_known = 1;
        end else begin
            lock = !wp && (m_sec(oa) inside {0, 1, 140, 141});
            m_ack = st && !m_busy && !lock;
            m_err = st && (m_busy || lock);
            if (m_ack) begin m_busy = 1; m_bb = m_bank(oa); end
            else if (fin) m_busy = 0;
        end
    endtask

    task automatic rd(int a, string req);
        cyc(0, 1, a, 0, 0, 0, 1, req);
    endtask

    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.chk_reg) begin
                check(e.req, "idle", idle, e.idle);
                check(e.req, "op_ack", op_ack, e.ack);
                check(e.req, "op_err", op_err, e.err);
                if (!e.idle) check(e.req, "busy_bank", busy_bank, e.bb);
            end
            if (e.rdv) begin
                check("R1", "rd_bank", rd_bank, e.bank);
                check("R2", "rd_sector", rd_sector, e.sec);
            end
            check(e.stat ? "R4" : "R3", "rd_use_status", rd_use_status, e.stat);
            check(e.stat ? "R4" : "R3", "rd_array_en", rd_array_en, e.arr);
        end
    end

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        cyc(1, 0, 0, 0, 0, 0, 1, "R10");
        cyc(1, 0, 0, 0, 0, 0, 1, "R10");
        // R1 and R2: region edges while idle
        rd('h000000, "R1"); rd('h001000, "R2"); rd('h007FFF, "R2"); rd('h008000, "R2");
        rd('h07FFFF, "R1"); rd('h080000, "R1"); rd('h1FFFFF, "R1"); rd('h200000, "R1");
        rd('h37FFFF, "R1"); rd('h380000, "R1"); rd('h3F7FFF, "R2"); rd('h3F8000, "R2");
        rd('h3FE000, "R2"); rd('h3FFFFF, "R2");
        cyc(0, 0, 0, 0, 0, 0, 1, "R4");
        // R5: start in bank 1, then reads around it
        cyc(0, 0, 0, 1, 'h100000, 0, 1, "R5");
        rd('h100000, "R5"); rd('h1FFFFF, "R4"); rd('h000000, "R3");
        rd('h250000, "R3"); rd('h3FFFFF, "R3");
        // R6: start while busy
        cyc(0, 1, 'h080000, 1, 'h000000, 0, 1, "R6");
        rd('h090000, "R6");
        // R8: finish, bank reads array again
        cyc(0, 1, 'h120000, 0, 0, 1, 1, "R8");
        rd('h120000, "R8");
        // R9: finish while idle
        cyc(0, 0, 0, 0, 0, 1, 1, "R9");
        cyc(0, 0, 0, 0, 0, 1, 1, "R9");
        rd('h000000, "R9");
        // R7: guarded sectors refused with protect low
        cyc(0, 0, 0, 1, 'h000000, 0, 0, "R7");
        cyc(0, 0, 0, 1, 'h001FFF, 0, 0, "R7");
        cyc(0, 0, 0, 1, 'h3FE000, 0, 0, "R7");
        cyc(0, 0, 0, 1, 'h3FF000, 0, 0, "R7");
        cyc(0, 0, 0, 1, 'h002000, 0, 0, "R7");
        rd('h002000, "R7");
        cyc(0, 0, 0, 0, 0, 1, 0, "R8");
        cyc(0, 0, 0, 1, 'h3FD000, 0, 0, "R7");
        rd('h3FD000, "R7");
        cyc(0, 0, 0, 0, 0, 1, 1, "R8");
        cyc(0, 0, 0, 1, 'h000000, 0, 1, "R7");
        rd('h000000, "R7");
        // R6 with finish in the same cycle: refused, yet freed
        cyc(0, 0, 0, 1, 'h300000, 1, 1, "R6");
        rd('h000000, "R6");
        // R10: reset while busy
        cyc(0, 0, 0, 1, 'h2A0000, 0, 1, "R5");
        rd('h2A0000, "R4");
        cyc(1, 1, 'h2A0000, 0, 0, 0, 1, "R10");
        rd('h2A0000, "R10");
        cyc(0, 0, 0, 0, 0, 0, 1, "R10");
        cyc(0, 0, 0, 0, 0, 0, 1, "R10");
        @(negedge clk); @(negedge clk);
        #3;
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule